// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block gathers seven one-cycle event pulses from a two-wire serial bus controller into sticky pending flags and gates them with a software-written enable mask. It drives one registered interrupt request and exposes a vector register. That register reports the code of the most urgent pending event that is also enabled.

Software uses a small register port with write enable, read enable, a two-bit address and 16-bit data. Reading the vector both reports the winning event and acknowledges it, so repeated vector reads drain the pending events in priority order. The access-ready and stop-detected flags can also be cleared by writing ones to the status register. The status register also mirrors two live levels from the bus engine: receive shift full and bus busy.

Top module: `irq_vector_gen`

## Requirements
- R1: After reset all pending flags, the enable mask, the interrupt line and the vector read value are zero.
- R2: An event pulse on `ev_i[i]` sets pending flag i at the next clock edge, and the flag stays set until it is cleared. The bit order is: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: Address 0 is the enable mask. A write loads `wdata[6:0]`, with bit i enabling event i. A read returns the mask in bits 6:0 and zero in bits 15:7.
- R4: Address 2 (vector) reads i+1 for the lowest index i whose flag is pending and enabled, which gives codes 1 through 7. It reads 0 when no enabled flag is pending. A pending flag whose enable bit is clear never appears in the vector.
- R5: A read of address 2 with `rd_en` clears the flag it reports at the next edge, so the next read returns the next pending event. A read that returns 0 clears nothing.
- R6: Address 1 (status) is cleared by writing a one only at bits 2 and 5. Ones written at bits 0, 1, 3, 4 and 6 leave those flags unchanged.
- R7: When an event pulse and a clear (status write or vector acknowledge) hit the same flag in one cycle, the flag stays set.
- R8: `irq_o` is registered. It is high one cycle after the AND of flags and mask is nonzero, and low one cycle after that AND is zero.
- R9: The status read returns the flags in bits 6:0, `rsfull_i` in bit 11 and `bus_busy_i` in bit 12, with all other bits zero. Address 3 reads zero, and writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 7 | One-cycle event pulses, bit order as in R2 |
| rsfull_i | input | 1 | Live receive-shift-full level |
| bus_busy_i | input | 1 | Live bus-busy level |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledges on vector reads) |
| addr | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 unused |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check these rules on every cycle:
- an event pulse always leaves its flag set;
- flags that cannot be written-one-cleared hold their value unless an event or an acknowledge touches them;
- a nonzero vector always names a pending, enabled flag;
- an acknowledged flag is gone the cycle after the read;
- the interrupt line rises only after a nonzero vector and falls only after a zero vector.

Priority among several simultaneous events, masking of the vector, draining through successive vector reads and the collision of an event with a clear can only be shown by the bench's scenarios. The same holds for the register map layout, the mirrored live levels and the ignored writes. The bench compares all of these against its own model, under directed cases and under seeded random traffic.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_STAT = 2'd1,
    REG_VEC  = 2'd2,
    REG_NONE = 2'd3
  } ivg_reg_e;

  localparam int EV_ARB_LOST = 0;
  localparam int EV_NO_ACK   = 1;
  localparam int EV_ACC_RDY  = 2;
  localparam int EV_RX_RDY   = 3;
  localparam int EV_TX_RDY   = 4;
  localparam int EV_STOP     = 5;
  localparam int EV_AS_SLAVE = 6;

endpackage

// File: rtl/ivg_flag_bank.sv
module ivg_flag_bank #(
  parameter int NUM_EV = 7,
  parameter logic [NUM_EV-1:0] W1C_SEL = 7'b0100100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [NUM_EV-1:0] w1c_i,
  input  logic [NUM_EV-1:0] ack_i,
  output logic [NUM_EV-1:0] flags_o
);

  logic [NUM_EV-1:0] flags_q;
  logic [NUM_EV-1:0] clr_hit;

  assign clr_hit = (w1c_i & W1C_SEL) | ack_i;
  assign flags_o = flags_q;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags_q[i] <= 1'b0;
      else if (ev_i[i])    flags_q[i] <= 1'b1;
      else if (clr_hit[i]) flags_q[i] <= 1'b0;
    end

    // R2 and R7: an event always leaves the flag set
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[i] |=> flags_q[i]);

    if (W1C_SEL[i]) begin : g_w1c
      a_r6_w1c_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i[i] && !ack_i[i] && !w1c_i[i]) |=> (flags_q[i] == $past(flags_q[i])));
    end else begin : g_fixed
      a_r6_no_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i[i] && !ack_i[i]) |=> (flags_q[i] == $past(flags_q[i])));
    end
  end

endmodule

// File: rtl/ivg_prio_enc.sv
module ivg_prio_enc #(
  parameter int NUM_EV = 7,
  localparam int VW = $clog2(NUM_EV + 1)
) (
  input  logic [NUM_EV-1:0] req_i,
  output logic [VW-1:0]     code_o,
  output logic [NUM_EV-1:0] grant_o
);

  function automatic logic [VW-1:0] first_code(input logic [NUM_EV-1:0] r);
    logic [VW-1:0] c;
    c = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (r[i]) c = VW'(i + 1);
    end
    return c;
  endfunction

  assign code_o = first_code(req_i);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_grant
    assign grant_o[i] = (code_o == VW'(i + 1));
  end

endmodule

// File: rtl/ivg_rd_mux.sv
module ivg_rd_mux
  import ivg_pkg::*;
#(
  parameter int NUM_EV  = 7,
  parameter int DW      = 16,
  parameter int RSF_BIT = 11,
  parameter int BB_BIT  = 12,
  localparam int VW = $clog2(NUM_EV + 1)
) (
  input  logic [1:0]        addr_i,
  input  logic [NUM_EV-1:0] mask_i,
  input  logic [NUM_EV-1:0] flags_i,
  input  logic [VW-1:0]     code_i,
  input  logic              rsfull_i,
  input  logic              busy_i,
  output logic [DW-1:0]     rdata_o
);

  always_comb begin
    rdata_o = '0;
    case (ivg_reg_e'(addr_i))
      REG_MASK: rdata_o[NUM_EV-1:0] = mask_i;
      REG_STAT: begin
        rdata_o[NUM_EV-1:0] = flags_i;
        rdata_o[RSF_BIT]    = rsfull_i;
        rdata_o[BB_BIT]     = busy_i;
      end
      REG_VEC:  rdata_o[VW-1:0] = code_i;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import ivg_pkg::*;
#(
  parameter int NUM_EV  = 7,
  parameter int DW      = 16,
  parameter int RSF_BIT = 11,
  parameter int BB_BIT  = 12,
  parameter logic [NUM_EV-1:0] W1C_SEL = 7'b0100100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              rsfull_i,
  input  logic              bus_busy_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_o
);

  localparam int VW = $clog2(NUM_EV + 1);

  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] flags;
  logic [NUM_EV-1:0] pend;
  logic [NUM_EV-1:0] grant;
  logic [NUM_EV-1:0] w1c_bits;
  logic [NUM_EV-1:0] ack_bits;
  logic [VW-1:0]     vec_code;
  logic              wr_mask, wr_stat, rd_vec;
  logic              irq_q;

  assign wr_mask  = wr_en && (ivg_reg_e'(addr) == REG_MASK);
  assign wr_stat  = wr_en && (ivg_reg_e'(addr) == REG_STAT);
  assign rd_vec   = rd_en && (ivg_reg_e'(addr) == REG_VEC);
  assign w1c_bits = wr_stat ? wdata[NUM_EV-1:0] : '0;
  assign ack_bits = rd_vec ? grant : '0;
  assign pend     = flags & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata[NUM_EV-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end
  assign irq_o = irq_q;

  ivg_flag_bank #(.NUM_EV(NUM_EV), .W1C_SEL(W1C_SEL)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev_i),
    .w1c_i   (w1c_bits),
    .ack_i   (ack_bits),
    .flags_o (flags)
  );

  ivg_prio_enc #(.NUM_EV(NUM_EV)) i_enc (
    .req_i   (pend),
    .code_o  (vec_code),
    .grant_o (grant)
  );

  ivg_rd_mux #(.NUM_EV(NUM_EV), .DW(DW), .RSF_BIT(RSF_BIT), .BB_BIT(BB_BIT)) i_mux (
    .addr_i   (addr),
    .mask_i   (mask_q),
    .flags_i  (flags),
    .code_i   (vec_code),
    .rsfull_i (rsfull_i),
    .busy_i   (bus_busy_i),
    .rdata_o  (rdata)
  );

  // R4: a nonzero code names a pending, enabled flag
  a_r4_code_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code != '0) |-> pend[int'(vec_code) - 1]);

  // R5: the acknowledged flag is gone next cycle unless re-raised
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && ((grant & ~ev_i) != '0)) |=> ((flags & $past(grant & ~ev_i)) == '0));

  // R8: interrupt edges follow the vector one cycle later
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(vec_code != '0));
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(vec_code == '0));

endmodule

// File: tb/test_irq_vector_gen.sv
module test_irq_vector_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  ev_i;
  logic        rsfull_i, bus_busy_i, wr_en, rd_en;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [6:0] m_flags, m_mask;
  logic       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_gen i_irq_vector_gen (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .rsfull_i(rsfull_i),
    .bus_busy_i(bus_busy_i), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  function automatic logic [2:0] exp_vec(logic [6:0] f, logic [6:0] m);
    logic [6:0] p;
    p = f & m;
    for (int i = 0; i < 7; i++) if (p[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [15:0] exp_rd(logic [1:0] a, logic rsf, logic bb);
    case (a)
      2'd0: return {9'd0, m_mask};
      2'd1: return {3'd0, bb, rsf, 4'd0, m_flags};
      2'd2: return {13'd0, exp_vec(m_flags, m_mask)};
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle; check read data and irq before the edge, then advance the model
  task automatic cyc(logic [6:0] ev, logic wr, logic rd, logic [1:0] a,
                     logic [15:0] wd, logic rsf, logic bb, string tag);
    logic [6:0] nf;
    logic [2:0] v;
    @(negedge clk);
    ev_i = ev; wr_en = wr; rd_en = rd; addr = a; wdata = wd;
    rsfull_i = rsf; bus_busy_i = bb;
    #1;
    check(tag, rdata, exp_rd(a, rsf, bb));
    check("R8 irq", {15'd0, irq_o}, {15'd0, m_irq});
    @(posedge clk);
    v  = exp_vec(m_flags, m_mask);
    nf = m_flags;
    if (wr && a == 2'd1) nf = nf & ~(wd[6:0] & 7'b0100100);
    if (rd && a == 2'd2 && v != 0) nf[v - 1] = 1'b0;
    nf = nf | ev;
    m_irq = |(m_flags & m_mask);
    m_flags = nf;
    if (wr && a == 2'd0) m_mask = wd[6:0];
  endtask

  task automatic idle_rd(logic [1:0] a, string tag);
    cyc(7'd0, 1'b0, 1'b0, a, 16'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c2a5));
    rst_n = 1'b0; ev_i = '0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    rsfull_i = 0; bus_busy_i = 0;
    m_flags = '0; m_mask = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    idle_rd(2'd0, "R1 mask");
    idle_rd(2'd1, "R1 status");
    idle_rd(2'd2, "R1 vector");

    // R3 mask write with high bits set, read back
    cyc(7'd0, 1, 0, 2'd0, 16'hFFFF, 0, 0, "R3 write");
    idle_rd(2'd0, "R3 readback");
    cyc(7'd0, 1, 0, 2'd0, 16'h0000, 0, 0, "R3 clear");

    // R2 each event alone, masked off: vector stays 0 (R4)
    for (int i = 0; i < 7; i++) begin
      cyc(7'(1 << i), 0, 0, 2'd1, 0, 0, 0, "R2 pulse");
      idle_rd(2'd1, "R2 sticky");
      idle_rd(2'd2, "R4 masked");
    end
    // enable all: lowest index wins, drain via vector reads (R4 R5)
    cyc(7'd0, 1, 0, 2'd0, 16'h007F, 0, 0, "R3 enable");
    idle_rd(2'd2, "R8 irq up");
    for (int i = 0; i < 8; i++) cyc(7'd0, 0, 1, 2'd2, 0, 0, 0, "R5 drain");
    idle_rd(2'd1, "R5 empty");
    idle_rd(2'd2, "R8 irq down");

    // R4 partial mask hides lower-index flag
    cyc(7'b0010101, 0, 0, 2'd1, 0, 0, 0, "R2 multi");
    cyc(7'd0, 1, 0, 2'd0, 16'h0014, 0, 0, "R3 partial");
    idle_rd(2'd2, "R4 partial mask");

    // R6 write ones to all status bits: only 2 and 5 clear
    cyc(7'b1011011, 0, 0, 2'd1, 0, 0, 0, "R2 set more");
    cyc(7'd0, 1, 0, 2'd1, 16'h007F, 0, 0, "R6 w1c");
    idle_rd(2'd1, "R6 result");

    // R7 event collides with w1c and with vector ack
    cyc(7'b0100100, 0, 0, 2'd1, 0, 0, 0, "R7 prep");
    cyc(7'b0000100, 1, 0, 2'd1, 16'h0024, 0, 0, "R7 w1c hit");
    idle_rd(2'd1, "R7 after w1c");
    cyc(7'b0000100, 0, 1, 2'd2, 0, 0, 0, "R7 ack hit");
    idle_rd(2'd1, "R7 after ack");

    // R9 live levels, unused address, ignored writes
    idle_rd(2'd1, "R9 none");
    cyc(7'd0, 0, 0, 2'd1, 0, 1, 0, "R9 rsfull");
    cyc(7'd0, 0, 0, 2'd1, 0, 0, 1, "R9 busy");
    cyc(7'd0, 1, 0, 2'd2, 16'hFFFF, 1, 1, "R9 vec write");
    cyc(7'd0, 1, 1, 2'd3, 16'hFFFF, 1, 1, "R9 addr3");
    idle_rd(2'd0, "R9 mask kept");
    idle_rd(2'd1, "R9 flags kept");

    // random traffic
    for (int k = 0; k < 600; k++) begin
      logic [1:0] a;
      logic wr, rd;
      logic [6:0] ev;
      a  = 2'($urandom_range(0, 3));
      wr = ($urandom_range(0, 3) == 0);
      rd = ($urandom_range(0, 1) == 0);
      ev = ($urandom_range(0, 2) == 0) ? 7'($urandom) : 7'd0;
      cyc(ev, wr, rd, a, 16'($urandom), 1'($urandom), 1'($urandom), "R4 R5 R6 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule